// File: doc/BRIEF.md
# Parallel Rule 110 Automaton Array

This block holds a one-dimensional row of single-bit cells and advances all of them together under elementary rule 110. Every clock edge produces one complete new generation of the row. No external command is needed to start: the row begins evolving on the first edge after reset leaves its seed.

A host reaches the row through a narrow port. It pulls an active-low hold input to pause the row. A block address then picks a group of eight neighbouring cells. Their values appear at once on an 8-bit read bus. To change a group, the host drives an 8-bit write word and pulses an active-low write strobe. The intended use is to pause, inspect or load a pattern group by group, and then release the hold to let the pattern evolve.

Top module: `r110_array`

## Requirements
- R1: A synchronous active-high reset loads the seed pattern: cell 0 (the rightmost cell) is 1 and every other cell is 0. After reset, block 0 reads 8'h01 and every other block reads 8'h00.
- R2: In a generation step, each cell's new value depends on its neighbourhood, written as (left, self, right). The mapping is 111→0, 110→1, 101→1, 100→0, 011→1, 010→1, 001→1, 000→0. An all-zero row therefore stays all zero.
- R3: A neighbour that lies beyond either end of the row counts as 0. There is no wrap-around. As a result, the leftmost cell's next value is the OR of itself and the cell to its right.
- R4: While hold_n is 1 and wr_n is 1, each rising clock edge applies one generation step to every cell at the same time.
- R5: While hold_n is 0 and wr_n is 1, no cell changes.
- R6: Cells are numbered 0 upward from the rightmost cell. Block address k selects cells 8k through 8k+7. Bit j of the 8-bit bus corresponds to cell 8k+j, so bit 0 is the rightmost cell of the block.
- R7: rd_data is combinational. It shows the block that blk_addr currently selects, within the same cycle, with no clock edge in between.
- R8: When wr_n is 0 at a rising edge, the addressed block takes wr_data on that edge. Cells outside that block do not take wr_data.
- R9: When wr_n is 0 and hold_n is 1 at the same edge, the write takes priority. No cell outside the addressed block advances on that edge.
- R10: Starting from reset and running for exactly 10 generations, block 0 reads 8'h0D, block 1 reads 8'h07, and every higher block reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the seed |
| hold_n | input | 1 | Active-low pause; 1 lets the row evolve |
| wr_n | input | 1 | Active-low write strobe for the addressed block |
| blk_addr | input | ADDR_W (5) | Block select; 0 is the rightmost eight cells |
| wr_data | input | BLK_W (8) | Word loaded into the addressed block |
| rd_data | output | BLK_W (8) | Current contents of the addressed block |

## Verification
The assertions assume that blk_addr never selects a block beyond the row. With the default sizes, the 5-bit address covers exactly 32 blocks. They also assume that inputs change only between clock edges. The bench drives every input on the falling edge and keeps every address inside the row. It follows the host protocol of separating writes with an idle cycle, and it also issues one write while the row is running in order to reach the priority case.

// File: rtl/r110_pkg.sv
package r110_pkg;

  // Rule number: bit {left,self,right} of this byte is the next value.
  localparam logic [7:0] RULE_CODE = 8'd110;

  function automatic logic rule_next(input logic left, input logic self_v, input logic right);
    logic [2:0] nbh;
    nbh = {left, self_v, right};
    return RULE_CODE[nbh];
  endfunction

endpackage

// File: rtl/r110_cell.sv
module r110_cell
  import r110_pkg::*;
#(
  parameter logic SEED_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic left_i,
  input  logic right_i,
  input  logic step_i,
  input  logic load_i,
  input  logic load_val_i,
  output logic state_o
);

  logic nxt;

  always_comb nxt = rule_next(left_i, state_o, right_i);

  // Load wins over stepping; hold otherwise.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= SEED_VAL;
    end else if (load_i) begin
      state_o <= load_val_i;
    end else if (step_i) begin
      state_o <= nxt;
    end
  end

endmodule

// File: rtl/r110_wr_decode.sv
module r110_wr_decode #(
  parameter int NUM_BLKS = 32,
  parameter int ADDR_W   = 5
) (
  input  logic              hold_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] blk_addr,
  output logic [NUM_BLKS-1:0] blk_we,
  output logic              step_en
);

  // Any write freezes evolution for the cycle.
  always_comb step_en = hold_n & wr_n;

  for (genvar b = 0; b < NUM_BLKS; b++) begin : g_dec
    always_comb blk_we[b] = !wr_n && (blk_addr == ADDR_W'(b));
  end

endmodule

// File: rtl/r110_read_mux.sv
module r110_read_mux #(
  parameter int NUM_CELLS = 256,
  parameter int BLK_W     = 8,
  parameter int ADDR_W    = 5
) (
  input  logic [NUM_CELLS-1:0] cells_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [BLK_W-1:0]     data_o
);

  localparam int NUM_BLKS = NUM_CELLS / BLK_W;

  always_comb begin
    data_o = '0;
    for (int b = 0; b < NUM_BLKS; b++) begin
      if (addr_i == ADDR_W'(b)) data_o = cells_i[b*BLK_W +: BLK_W];
    end
  end

endmodule

// File: rtl/r110_array.sv
module r110_array #(
  parameter int NUM_CELLS = 256,
  parameter int BLK_W     = 8,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] blk_addr,
  input  logic [BLK_W-1:0]  wr_data,
  output logic [BLK_W-1:0]  rd_data
);

  localparam int NUM_BLKS = NUM_CELLS / BLK_W;

  logic [NUM_CELLS-1:0] cells;
  logic [NUM_CELLS+1:0] padded;
  logic [NUM_BLKS-1:0]  blk_we;
  logic                 step_en;

  // Zero guard cells at both ends: no wrap-around.
  always_comb padded = {1'b0, cells, 1'b0};

  r110_wr_decode #(
    .NUM_BLKS (NUM_BLKS),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .hold_n   (hold_n),
    .wr_n     (wr_n),
    .blk_addr (blk_addr),
    .blk_we   (blk_we),
    .step_en  (step_en)
  );

  for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
    for (genvar k = 0; k < BLK_W; k++) begin : g_bit
      localparam int IDX = b*BLK_W + k;
      r110_cell #(
        .SEED_VAL ((IDX == 0) ? 1'b1 : 1'b0)
      ) u_cell (
        .clk        (clk),
        .rst        (rst),
        .left_i     (padded[IDX+2]),
        .right_i    (padded[IDX]),
        .step_i     (step_en),
        .load_i     (blk_we[b]),
        .load_val_i (wr_data[k]),
        .state_o    (cells[IDX])
      );
    end
  end

  r110_read_mux #(
    .NUM_CELLS (NUM_CELLS),
    .BLK_W     (BLK_W),
    .ADDR_W    (ADDR_W)
  ) u_rd (
    .cells_i (cells),
    .addr_i  (blk_addr),
    .data_o  (rd_data)
  );

endmodule

// File: rtl/r110_array_chk.sv
module r110_array_chk #(
  parameter int NUM_CELLS = 256,
  parameter int BLK_W     = 8,
  parameter int ADDR_W    = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 hold_n,
  input logic                 wr_n,
  input logic [ADDR_W-1:0]    blk_addr,
  input logic [BLK_W-1:0]     wr_data,
  input logic [BLK_W-1:0]     rd_data,
  input logic [NUM_CELLS-1:0] cells
);

  localparam logic [NUM_CELLS-1:0] SEED = {{(NUM_CELLS-1){1'b0}}, 1'b1};

  function automatic logic [BLK_W-1:0] sel_blk(input logic [NUM_CELLS-1:0] v,
                                               input logic [ADDR_W-1:0] a);
    logic [NUM_CELLS-1:0] sh;
    sh = v >> (int'(a) * BLK_W);
    return sh[BLK_W-1:0];
  endfunction

  function automatic logic [NUM_CELLS-1:0] blk_mask(input logic [ADDR_W-1:0] a);
    logic [NUM_CELLS-1:0] m;
    m = '0;
    m[BLK_W-1:0] = '1;
    return m << (int'(a) * BLK_W);
  endfunction

  assert_seed_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cells == SEED));

  assert_zero_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    (hold_n && wr_n && cells == '0) |=> (cells == '0));

  assert_left_edge_R3: assert property (@(posedge clk) disable iff (rst)
    (hold_n && wr_n) |=>
      (cells[NUM_CELLS-1] == ($past(cells[NUM_CELLS-1]) | $past(cells[NUM_CELLS-2]))));

  assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (!hold_n && wr_n) |=> $stable(cells));

  assert_read_R7: assert property (@(posedge clk) disable iff (rst)
    rd_data == sel_blk(cells, blk_addr));

  assert_write_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> (sel_blk(cells, $past(blk_addr)) == $past(wr_data)));

  assert_no_advance_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> (((cells ^ $past(cells)) & ~blk_mask($past(blk_addr))) == '0));

endmodule

bind r110_array r110_array_chk #(
  .NUM_CELLS (NUM_CELLS),
  .BLK_W     (BLK_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .hold_n   (hold_n),
  .wr_n     (wr_n),
  .blk_addr (blk_addr),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .cells    (cells)
);

// File: tb/r110_array_bench.sv
module r110_array_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 256;
  localparam int NB = NC / 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold_n = 1'b0;
  logic       wr_n = 1'b1;
  logic [4:0] blk_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit mdl [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  r110_array u_r110_array (
    .clk      (clk),
    .rst      (rst),
    .hold_n   (hold_n),
    .wr_n     (wr_n),
    .blk_addr (blk_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data)
  );

  function automatic logic [7:0] mblk(input int a);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = mdl[a*8 + k];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: rule number 110 looked up by neighbourhood index.
  task automatic model_edge();
    bit nxt [NC];
    int l, s, r;
    if (rst) begin
      foreach (mdl[i]) mdl[i] = (i == 0);
    end else if (!wr_n) begin
      for (int k = 0; k < 8; k++) mdl[int'(blk_addr)*8 + k] = wr_data[k];
    end else if (hold_n) begin
      for (int i = 0; i < NC; i++) begin
        l = (i == NC-1) ? 0 : int'(mdl[i+1]);
        s = int'(mdl[i]);
        r = (i == 0) ? 0 : int'(mdl[i-1]);
        nxt[i] = ((110 >> (l*4 + s*2 + r)) & 1) != 0;
      end
      foreach (mdl[i]) mdl[i] = nxt[i];
    end
  endtask

  // One cycle: drive on the falling edge, check the combinational read, follow the edge.
  task automatic tick(input bit r, input bit h, input bit w, input int a,
                      input logic [7:0] d, input string req);
    @(negedge clk);
    rst = r; hold_n = h; wr_n = w; blk_addr = 5'(a); wr_data = d;
    #1;
    if (!r) chk(rd_data === mblk(a), req, rd_data, mblk(a));
    @(posedge clk);
    model_edge();
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < NB; a++) tick(0, 0, 1, a, 8'h00, req);
  endtask

  task automatic sweep_expect(input logic [7:0] e0, input logic [7:0] e1, input string req);
    logic [7:0] e;
    for (int a = 0; a < NB; a++) begin
      e = (a == 0) ? e0 : (a == 1) ? e1 : 8'h00;
      @(negedge clk);
      hold_n = 0; wr_n = 1; blk_addr = 5'(a);
      #1;
      chk(rd_data === e, req, rd_data, e);
      @(posedge clk);
      model_edge();
    end
  endtask

  initial begin
    foreach (mdl[i]) mdl[i] = 0;
    // Reset
    tick(1, 0, 1, 0, 8'h00, "R1");
    tick(1, 0, 1, 0, 8'h00, "R1");
    sweep_expect(8'h01, 8'h00, "R1 R6");
    // Ten generations from the seed
    for (int i = 0; i < 10; i++) tick(0, 1, 1, i % 2, 8'h00, "R4 R7");
    sweep_expect(8'h0D, 8'h07, "R10");
    // Frozen while held
    for (int i = 0; i < 6; i++) tick(0, 0, 1, 0, 8'h00, "R5");
    sweep_expect(8'h0D, 8'h07, "R5");
    // Block writes with idle gaps
    tick(0, 0, 0, 0, 8'h07, "R8");
    tick(0, 0, 1, 0, 8'h00, "R8");
    tick(0, 0, 0, 1, 8'hE6, "R8");
    tick(0, 0, 1, 1, 8'h00, "R8");
    tick(0, 0, 0, 2, 8'hD7, "R8");
    tick(0, 0, 1, 2, 8'h00, "R8 R6");
    sweep("R8 R6");
    // Evolve the written pattern: all neighbourhoods appear
    for (int i = 0; i < 12; i++) tick(0, 1, 1, i % 4, 8'h00, "R2 R4");
    sweep("R2");
    // Left edge: load the top block and run
    tick(0, 0, 0, NB-1, 8'hC0, "R8");
    tick(0, 0, 1, NB-1, 8'h00, "R3");
    tick(0, 0, 0, NB-2, 8'h35, "R8");
    tick(0, 0, 1, NB-2, 8'h00, "R3");
    for (int i = 0; i < 8; i++) tick(0, 1, 1, NB-1, 8'h00, "R3");
    sweep("R3");
    // Write while running: write wins, nothing else advances
    tick(0, 1, 1, 3, 8'h00, "R4");
    tick(0, 1, 0, 5, 8'hA5, "R9");
    tick(0, 0, 1, 5, 8'h00, "R9");
    sweep("R9");
    tick(0, 1, 0, NB-1, 8'h5A, "R9");
    tick(0, 0, 1, NB-1, 8'h00, "R9");
    sweep("R9");
    // Address changes read back within the cycle
    for (int a = NB-1; a >= 0; a -= 3) tick(0, 1, 1, a, 8'h00, "R7");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule